// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Engine

This block sits on the host side of a three-wire serial EEPROM link. A client hands it one command at a time (an operation code, a word address and, for writes, a data word) over a valid/ready handshake. The engine frames the instruction on the chip-select, serial-clock and serial-data-out wires, reads the serial-data-in wire, and reports completion with a one-cycle response that carries the read word or an error flag.

Every bit is clocked with programmable low and high phases counted in system clocks. Read data is taken most significant bit first, and the leading zero that the memory emits is thrown away. After any instruction that programs the array, the engine drops chip select for a programmable rest time and then raises it again. It then watches the returned line each clock until the memory reports ready or a poll limit runs out.

Top module: `eep_host`

## Requirements
- R1: Out of reset, memCs, memSk and memDi are 0, rspValid is 0 and cmdReady is 1. Whenever cmdReady is 1, memCs and memSk are 0.
- R2: An accepted command is sent as one frame with memCs held high. The frame is a 1 start bit, then a two-bit code (read 10, write 01, erase 11, all others 00), then ADDR_W address bits MSB first. Write and write-all then add WORD_W data bits, MSB first. cmdOp encodings are: 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all.
- R3: Enable, disable, erase-all and write-all use code 00. Their top two address bits are 11, 00, 10 and 01 respectively, and every remaining address position is sent as 0 and still clocked.
- R4: Each bit has memSk low for SK_LOW_CYC clocks and then high for SK_HIGH_CYC clocks. memDi changes only at the start of a low phase, so it is stable whenever memSk is high. memSk is never high while memCs is low.
- R5: A read clocks WORD_W further bits after the address with memDi at 0. memDo is sampled in the last clock of each high phase, from the final address bit onward. The first sample (the dummy 0) is dropped, and the next WORD_W samples form rspRdata, MSB first.
- R6: Every frame ends with memCs and memSk low. memCs then stays low for CS_LOW_CYC clocks before it rises again or before the response.
- R7: After write, erase, erase-all or write-all, memCs is raised with memSk low and memDo is sampled every clock. The clock after memDo reads 1, memCs falls. After the rest time the response has rspErr 0.
- R8: If memDo stays 0 for POLL_LIMIT poll clocks, memCs falls and the response carries rspErr 1.
- R9: A command is taken on a clock where cmdValid and cmdReady are both 1. rspValid is a single-cycle pulse, and it comes in the clock after the last rest clock.
- R10: Read, enable and disable do not poll, so memCs stays low from the frame end through the response.
- R11: ADDR_W equals ADDR_W16 when WORD_W is 16 and ADDR_W16+1 when WORD_W is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle and able to take a command |
| cmdOp | input | 3 | Operation code (encoding in R2) |
| cmdAddr | input | ADDR_W | Word address |
| cmdWdata | input | WORD_W | Data for write and write-all |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Poll timed out (valid with rspValid) |
| rspRdata | output | WORD_W | Word returned by a read |
| memCs | output | 1 | Chip select to the memory |
| memSk | output | 1 | Serial clock to the memory |
| memDi | output | 1 | Serial data into the memory |
| memDo | input | 1 | Serial data and ready status from the memory |

## Verification
The bench runs addresses at zero, mid and top of range with data words of mixed bit density. This separates an MSB-first shift from a reversed one, and a dropped dummy from a kept one. Programming commands are sent both before and after the enable instruction, and the read-backs that follow tell a memory that ignored the write from one that took it. Busy periods are chosen so that ready arrives on the first poll clock, in the middle of the poll, exactly on the last allowed poll clock, and never. These cases expose off-by-one errors in the poll limit.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_EWEN  = 3'd3,
    OP_EWDS  = 3'd4,
    OP_ERAL  = 3'd5,
    OP_WRAL  = 3'd6
  } eepOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic skRise;
    logic nextBit;
    logic capture;
    logic endFrame;
    logic csRaise;
    logic csDrop;
    logic finish;
    logic finErr;
  } eepStrobe_t;

endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int SK_LOW_CYC  = 63,
  parameter int SK_HIGH_CYC = 63,
  parameter int CS_LOW_CYC  = 63,
  parameter int POLL_LIMIT  = 1275000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       memDo,
  output logic       cmdReady,
  output eepStrobe_t str
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int PH_A    = (SK_LOW_CYC > SK_HIGH_CYC) ? SK_LOW_CYC : SK_HIGH_CYC;
  localparam int PH_MAX  = (PH_A > CS_LOW_CYC) ? PH_A : CS_LOW_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_GAP, S_POLL} state_e;

  state_e              state, stateN;
  logic [PH_W-1:0]     phase, phaseN;
  logic [BIT_W-1:0]    bitIdx, bitN;
  logic [POLL_W-1:0]   pollCnt, pollN;
  eepOp_e              opReg, opN;
  logic                polled, polledN;
  logic                errFlag, errN;
  logic [BIT_W-1:0]    lastBit;
  logic                isProg;

  always_comb begin
    lastBit = (opReg == OP_READ || opReg == OP_WRITE || opReg == OP_WRAL)
              ? BIT_W'(FRAME_W - 1) : BIT_W'(HDR_W - 1);
    isProg  = (opReg == OP_WRITE) || (opReg == OP_ERASE) ||
              (opReg == OP_ERAL)  || (opReg == OP_WRAL);
  end

  assign cmdReady = (state == S_IDLE);

  always_comb begin
    str     = '0;
    stateN  = state;
    phaseN  = phase;
    bitN    = bitIdx;
    pollN   = pollCnt;
    opN     = opReg;
    polledN = polled;
    errN    = errFlag;
    case (state)
      S_IDLE: if (cmdValid) begin
        str.load = 1'b1;
        opN      = eepOp_e'(cmdOp);
        bitN     = '0;
        phaseN   = PH_W'(SK_LOW_CYC - 1);
        polledN  = 1'b0;
        errN     = 1'b0;
        stateN   = S_LOW;
      end
      S_LOW: begin
        if (phase == '0) begin
          str.skRise = 1'b1;
          phaseN     = PH_W'(SK_HIGH_CYC - 1);
          stateN     = S_HIGH;
        end else phaseN = phase - 1'b1;
      end
      S_HIGH: begin
        if (phase == '0) begin
          str.capture = (opReg == OP_READ) && (bitIdx >= BIT_W'(HDR_W - 1));
          if (bitIdx == lastBit) begin
            str.endFrame = 1'b1;
            phaseN       = PH_W'(CS_LOW_CYC - 1);
            stateN       = S_GAP;
          end else begin
            str.nextBit = 1'b1;
            bitN        = bitIdx + 1'b1;
            phaseN      = PH_W'(SK_LOW_CYC - 1);
            stateN      = S_LOW;
          end
        end else phaseN = phase - 1'b1;
      end
      S_GAP: begin
        if (phase == '0) begin
          if (isProg && !polled) begin
            str.csRaise = 1'b1;
            pollN       = '0;
            stateN      = S_POLL;
          end else begin
            str.finish = 1'b1;
            str.finErr = errFlag;
            stateN     = S_IDLE;
          end
        end else phaseN = phase - 1'b1;
      end
      S_POLL: begin
        if (memDo) begin
          str.csDrop = 1'b1;
          polledN    = 1'b1;
          phaseN     = PH_W'(CS_LOW_CYC - 1);
          stateN     = S_GAP;
        end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
          str.csDrop = 1'b1;
          polledN    = 1'b1;
          errN       = 1'b1;
          phaseN     = PH_W'(CS_LOW_CYC - 1);
          stateN     = S_GAP;
        end else pollN = pollCnt + 1'b1;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      bitIdx  <= '0;
      pollCnt <= '0;
      opReg   <= OP_READ;
      polled  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      bitIdx  <= bitN;
      pollCnt <= pollN;
      opReg   <= opN;
      polled  <= polledN;
      errFlag <= errN;
    end
  end

  // R8: the poll never runs past its limit
  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_POLL) |-> (pollCnt < POLL_W'(POLL_LIMIT)));

  // R9: a taken command always leaves idle on the next clock
  p_accept_leaves_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

endmodule

// File: rtl/eep_dp.sv
module eep_dp
  import eep_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int CS_LOW_CYC = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  eepStrobe_t        str,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [WORD_W-1:0] cmdWdata,
  input  logic              memDo,
  output logic              memCs,
  output logic              memSk,
  output logic              memDi,
  output logic              rspValid,
  output logic              rspErr,
  output logic [WORD_W-1:0] rspRdata
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int PAD_W   = ADDR_W - 2;
  localparam int RUN_W   = $clog2(CS_LOW_CYC + 1);

  logic [1:0]         opCode;
  logic [ADDR_W-1:0]  addrField;
  logic [WORD_W-1:0]  dataField;
  logic [FRAME_W-1:0] frameNext;
  logic [FRAME_W-1:0] shReg;
  logic [WORD_W:0]    rdShift;

  always_comb begin
    opCode    = 2'b00;
    addrField = cmdAddr;
    dataField = '0;
    case (eepOp_e'(cmdOp))
      OP_READ:  opCode = 2'b10;
      OP_WRITE: begin opCode = 2'b01; dataField = cmdWdata; end
      OP_ERASE: opCode = 2'b11;
      OP_EWEN:  addrField = {2'b11, {PAD_W{1'b0}}};
      OP_EWDS:  addrField = {2'b00, {PAD_W{1'b0}}};
      OP_ERAL:  addrField = {2'b10, {PAD_W{1'b0}}};
      OP_WRAL:  begin addrField = {2'b01, {PAD_W{1'b0}}}; dataField = cmdWdata; end
      default:  addrField = '0;
    endcase
    frameNext = {1'b1, opCode, addrField, dataField};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCs    <= 1'b0;
      memSk    <= 1'b0;
      memDi    <= 1'b0;
      shReg    <= '0;
      rdShift  <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      if (str.load) begin
        memCs   <= 1'b1;
        memSk   <= 1'b0;
        memDi   <= frameNext[FRAME_W-1];
        shReg   <= frameNext << 1;
        rdShift <= '0;
      end
      if (str.skRise) memSk <= 1'b1;
      if (str.capture) rdShift <= {rdShift[WORD_W-1:0], memDo};
      if (str.nextBit) begin
        memSk <= 1'b0;
        memDi <= shReg[FRAME_W-1];
        shReg <= shReg << 1;
      end
      if (str.endFrame) begin
        memCs <= 1'b0;
        memSk <= 1'b0;
        memDi <= 1'b0;
      end
      if (str.csRaise) memCs <= 1'b1;
      if (str.csDrop)  memCs <= 1'b0;
      if (str.finish) begin
        rspValid <= 1'b1;
        rspErr   <= str.finErr;
        rspRdata <= rdShift[WORD_W-1:0];
      end
    end
  end

  // checker state: consecutive low clocks on chip select
  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= RUN_W'(CS_LOW_CYC);
    else if (memCs) lowRun <= '0;
    else if (lowRun < RUN_W'(CS_LOW_CYC)) lowRun <= lowRun + 1'b1;
  end

  p_sk_inside_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    memSk |-> memCs);

  p_di_steady_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    memSk |-> $stable(memDi));

  p_cs_rest_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCs) |-> (lowRun >= RUN_W'(CS_LOW_CYC)));

  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/eep_host.sv
module eep_host
  import eep_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W16    = 6,
  parameter int SK_LOW_CYC  = 63,
  parameter int SK_HIGH_CYC = 63,
  parameter int CS_LOW_CYC  = 63,
  parameter int POLL_LIMIT  = 1275000,
  localparam int ADDR_W     = (WORD_W == 16) ? ADDR_W16 : ADDR_W16 + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [WORD_W-1:0] cmdWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [WORD_W-1:0] rspRdata,
  output logic              memCs,
  output logic              memSk,
  output logic              memDi,
  input  logic              memDo
);
  eepStrobe_t str;

  eep_ctrl #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SK_LOW_CYC(SK_LOW_CYC),
    .SK_HIGH_CYC(SK_HIGH_CYC), .CS_LOW_CYC(CS_LOW_CYC), .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .memDo(memDo), .cmdReady(cmdReady), .str(str)
  );

  eep_dp #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CS_LOW_CYC(CS_LOW_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .memDo(memDo), .memCs(memCs), .memSk(memSk),
    .memDi(memDi), .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
  );

  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (!memCs && !memSk));

  p_done_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memCs);

endmodule

// File: tb/eep_host_test.sv
module eep_host_test;
  localparam int WW  = 16;
  localparam int A16 = 6;
  localparam int AW  = (WW == 16) ? A16 : A16 + 1;  // R11 derivation, own copy
  localparam int SKL = 3;
  localparam int SKH = 2;
  localparam int CSL = 4;
  localparam int PL  = 40;
  localparam int HDR = 3 + AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [2:0] cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [WW-1:0] cmdWdata = '0;
  logic rspValid, rspErr;
  logic [WW-1:0] rspRdata;
  logic memCs, memSk, memDi;
  logic memDo;

  always #2 clk = ~clk;  // 250 MHz

  eep_host #(.WORD_W(WW), .ADDR_W16(A16), .SK_LOW_CYC(SKL), .SK_HIGH_CYC(SKH),
             .CS_LOW_CYC(CSL), .POLL_LIMIT(PL)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspRdata(rspRdata), .memCs(memCs), .memSk(memSk),
    .memDi(memDi), .memDo(memDo));

  int checks = 0;
  int errors = 0;
  bit running = 0;

  // ---------------- behavioural memory model ----------------
  logic [WW-1:0] mem [1<<AW];
  bit prevCs = 0, prevSk = 0, doOut = 0, enabled = 0, pendProg = 0, rdMode = 0;
  int bitCnt = 0, busyCnt = 0, devBusy = 0, dOp = 0, dAddr = 0;
  logic [63:0] sh = '0;
  logic [WW-1:0] outWord = '0;
  assign memDo = doOut;

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = '0;

  always @(negedge clk) begin
    bit rise;
    logic [AW-1:0] a;
    rise = memSk && !prevSk;
    if (busyCnt > 0) busyCnt--;
    if (!memCs) begin
      if (prevCs && pendProg) begin busyCnt = devBusy; pendProg = 0; end
      bitCnt = 0; rdMode = 0; dOp = 0;
    end else if (rise) begin
      if (rdMode) begin
        doOut = outWord[WW-1];
        outWord = outWord << 1;
      end else if (bitCnt > 0 || memDi) begin
        sh = {sh[62:0], memDi};
        bitCnt++;
        if (bitCnt == HDR) begin
          a = sh[AW-1:0];
          case (sh[AW+1:AW])
            2'b10: begin rdMode = 1; doOut = 0; outWord = mem[a]; end
            2'b11: begin if (enabled) mem[a] = '1; pendProg = enabled; end
            2'b01: begin dOp = 1; dAddr = int'(a); end
            default: case (a[AW-1:AW-2])
              2'b11: enabled = 1;
              2'b00: enabled = 0;
              2'b10: begin
                if (enabled) for (int i = 0; i < (1 << AW); i++) mem[i] = '1;
                pendProg = enabled;
              end
              default: dOp = 2;
            endcase
          endcase
        end
        if (bitCnt == HDR + WW && dOp != 0) begin
          if (enabled) begin
            if (dOp == 1) mem[dAddr] = sh[WW-1:0];
            else for (int i = 0; i < (1 << AW); i++) mem[i] = sh[WW-1:0];
          end
          pendProg = enabled;
        end
      end
    end else if (!memSk && bitCnt == 0 && !rdMode) begin
      doOut = (busyCnt == 0);
    end
    prevCs = memCs;
    prevSk = memSk;
  end

  // ---------------- expected-waveform queue ----------------
  typedef struct {
    bit cs, sk, di, rv, chkRd, err;
    logic [WW-1:0] rd;
    string tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(bit cs, bit sk, bit di, string tag);
    exp_t e;
    e.cs = cs; e.sk = sk; e.di = di; e.rv = 0; e.chkRd = 0; e.err = 0;
    e.rd = '0; e.tag = tag;
    return e;
  endfunction

  task automatic pushN(int n, bit cs, bit sk, bit di, string tag);
    for (int i = 0; i < n; i++) q.push_back(mk(cs, sk, di, tag));
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // compared every clock, away from the active edge
  always @(negedge clk) if (running) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = mk(0, 0, 0, "R1");
    chk(memCs == e.cs, e.tag, "memCs", int'(memCs), int'(e.cs));
    chk(memSk == e.sk, e.tag, "memSk", int'(memSk), int'(e.sk));
    chk(memDi == e.di, e.tag, "memDi", int'(memDi), int'(e.di));
    chk(rspValid == e.rv, "R9", "rspValid", int'(rspValid), int'(e.rv));
    if (e.rv) begin
      chk(rspErr == e.err, e.err ? "R8" : "R7", "rspErr", int'(rspErr), int'(e.err));
      if (e.chkRd) chk(rspRdata == e.rd, "R5", "rspRdata", int'(rspRdata), int'(e.rd));
    end
  end

  // op: 0 read 1 write 2 erase 3 enable 4 disable 5 erase-all 6 write-all
  task automatic issue(int op, int addr, int wd, int rdExp, int busy, string tag);
    int bits[$];
    int opc, af, k;
    bit prog, rd, err;
    exp_t e;
    rd   = (op == 0);
    prog = (op == 1 || op == 2 || op == 5 || op == 6);
    opc  = (op == 0) ? 2 : (op == 1) ? 1 : (op == 2) ? 3 : 0;
    case (op)
      3: af = 3 << (AW - 2);   // R3 enable 11
      4: af = 0;               // R3 disable 00
      5: af = 2 << (AW - 2);   // R3 erase-all 10
      6: af = 1 << (AW - 2);   // R3 write-all 01
      default: af = addr;
    endcase
    bits.push_back(1);
    bits.push_back((opc >> 1) & 1);
    bits.push_back(opc & 1);
    for (int i = AW - 1; i >= 0; i--) bits.push_back((af >> i) & 1);
    if (op == 1 || op == 6) for (int i = WW - 1; i >= 0; i--) bits.push_back((wd >> i) & 1);
    if (rd) for (int i = 0; i < WW; i++) bits.push_back(0);
    wait (q.size() == 0);
    @(negedge clk); #1;
    devBusy  = busy;
    cmdOp    = 3'(op);
    cmdAddr  = AW'(addr);
    cmdWdata = WW'(wd);
    cmdValid = 1'b1;
    foreach (bits[i]) begin
      pushN(SKL, 1, 0, bits[i][0], tag);   // R4 low phase
      pushN(SKH, 1, 1, bits[i][0], tag);   // R4 high phase
    end
    pushN(CSL, 0, 0, 0, "R6");
    err = 0;
    if (prog) begin
      k = (busy > CSL) ? busy - CSL : 0;
      if (k + 1 <= PL) pushN(k + 1, 1, 0, 0, "R7");
      else begin pushN(PL, 1, 0, 0, "R8"); err = 1; end
      pushN(CSL, 0, 0, 0, "R6");
    end
    // R10: no poll for read, enable, disable
    e = mk(0, 0, 0, "R9");
    e.rv = 1; e.err = err; e.chkRd = rd; e.rd = WW'(rdExp);
    q.push_back(e);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    wait (q.size() == 0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmdReady == 1'b1, "R1", "cmdReady", int'(cmdReady), 1);
    chk(!memCs && !memSk && !memDi, "R1", "pins", int'({memCs, memSk, memDi}), 0);
    chk(rspValid == 1'b0, "R1", "rspValid", int'(rspValid), 0);
    running = 1;

    issue(1, 5, 16'h1111, 0, 0, "R2");       // write before enable: ignored, ready at once
    issue(0, 5, 0, 16'h0000, 0, "R5");       // R5 read shows untouched word
    issue(3, 0, 0, 0, 0, "R3");              // R3 enable, R10 no poll
    issue(1, 5, 16'hA5C3, 0, 25, "R2");      // R7 mid-poll ready
    issue(0, 5, 0, 16'hA5C3, 0, "R5");
    issue(1, 63, 16'h8001, 0, CSL, "R2");    // R7 ready on first poll clock
    issue(0, 63, 0, 16'h8001, 0, "R5");
    issue(2, 5, 0, 0, 10, "R2");             // erase
    issue(0, 5, 0, 16'hFFFF, 0, "R5");
    issue(6, 0, 16'h1234, 0, 30, "R3");      // write-all
    issue(0, 0, 0, 16'h1234, 0, "R5");
    issue(0, 62, 0, 16'h1234, 0, "R5");
    issue(5, 0, 0, 0, CSL + PL - 1, "R3");   // R7 ready on the last allowed poll clock
    issue(0, 9, 0, 16'hFFFF, 0, "R5");
    issue(1, 7, 16'h0F0F, 0, 100, "R8");     // R8 timeout
    repeat (120) @(negedge clk);
    issue(0, 7, 0, 16'h0F0F, 0, "R5");
    issue(4, 0, 0, 0, 0, "R3");              // disable
    issue(1, 7, 16'h5555, 0, 0, "R2");       // ignored write
    issue(0, 7, 0, 16'h0F0F, 0, "R5");
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule